// File: doc/BRIEF.md
# EEPROM Program/Erase Sequencing Controller

This block runs the program and erase sequence for a small byte-wide nonvolatile array, held here as a register file. Software drives the sequence through an 8-bit control register. It first enables the latch, then writes one address/data pair through the array port or the configuration port, and then raises the program-voltage bit. It later lowers that bit to commit the operation. The commit happens only if the voltage bit stayed on for at least `MIN_CYCLES` clock edges.

Program operations can only clear bits. Erase operations come in three sizes, chosen by the control bits: a single byte, a 16-byte row, or the whole array. The last array location holds a configuration byte. This byte is not visible through the array port. It is copied into a live configuration register after each reset, and the enable bit of that copy decides whether array reads return data.

Every misuse of the sequence sets a sticky error flag. The flags stay set until they are cleared by a pulse on `err_clr_i`.

Top module: `eep_seq_ctrl`

## Requirements
- R1: Control bits are pgm=bit0, lat=bit1, erase=bit2, row=bit3, byte=bit4. A control write that sets lat and pgm while both are currently clear is rejected. The control register keeps its value and err_o bit0 is set.
- R2: A control write with lat=0 loads the control register with 0x00, and the register reads back as 0x00 from the next cycle. When the register holds pgm=1, it also holds lat=1.
- R3: An accepted control write with pgm=1 sets err_o bit1 if no address/data pair is latched or if lat was not already set. The write itself still takes effect.
- R4: With lat=1 and nothing pending, one array write (address below DEPTH-1) or one configuration write latches a pair; the configuration write latches address DEPTH-1. A write while a pair is pending, or while lat=0, sets err_o bit3 and latches nothing.
- R5: The elapsed time is the number of clock edges between the write that sets pgm and the write that clears it. If it is below MIN_CYCLES, err_o bit2 is set and the array is left unchanged. Otherwise the pending pair is committed at that clock edge. Either way the pending pair is discarded.
- R6: With erase=0, a commit replaces the latched byte with (old AND data).
- R7: With erase=1 and byte=1, or with erase=1 aimed at address DEPTH-1, a commit sets only that byte to 0xFF.
- R8: With erase=1, byte=0 and row=1, a commit sets the 16 bytes of the aligned row that holds the address to 0xFF. The last row includes the configuration byte.
- R9: With erase=1, byte=0 and row=0, a commit sets every byte to 0xFF, the configuration byte included.
- R10: An array read with arr_re_i=1 while lat=1 sets err_o bit4. Array read data is combinational. Address DEPTH-1 always reads 0xFF on the array port.
- R11: Reset clears the control register, the pending pair and err_o. On the first clock after reset, cfg_rdata_o loads the stored configuration byte and then holds that value until the next reset.
- R12: When bit0 of cfg_rdata_o is 0, arr_en_o is 0 and array reads return 0x00.
- R13: err_o bits stay set until err_clr_i is pulsed. An error raised in the same cycle as the clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| cfg_we_i | input | 1 | Write strobe to the stored configuration byte |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Live configuration register |
| arr_we_i | input | 1 | Array write strobe |
| arr_re_i | input | 1 | Array read strobe |
| arr_addr_i | input | ADDR_W | Array address |
| arr_wdata_i | input | 8 | Array write data |
| arr_rdata_o | output | 8 | Array read data |
| err_clr_i | input | 1 | Clears all error flags |
| err_o | output | 5 | Sticky error flags |
| arr_en_o | output | 1 | Array mapped for reads |

## Verification
The bench holds the voltage bit for exactly one cycle less than the minimum and for exactly the minimum. A design that counts from the wrong edge would commit the short pulse or reject the legal one. Row erases are aimed at the middle of a row and at the last row, so a design that does not align the address would clear the wrong bytes, and one that stops before the last byte would leave the configuration byte programmed. A configuration write is made and then checked for its effect across a reset: a design that updated the live register at once, or that dropped the enable decode, would show wrong data or the wrong mapping. Random program and erase sequences, with hold times spread around the limit, are compared after every commit against a model of the whole array.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CB_PGM   = 0;
  localparam int CB_LAT   = 1;
  localparam int CB_ERASE = 2;
  localparam int CB_ROW   = 3;
  localparam int CB_BYTE  = 4;

  localparam int E_ILL  = 0;
  localparam int E_SEQ  = 1;
  localparam int E_TIME = 2;
  localparam int E_WR   = 3;
  localparam int E_RD   = 4;
  localparam int ERR_W  = 5;

  localparam int CFG_EN_BIT = 0;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_BYTE = 2'd1,
    OP_ROW  = 2'd2,
    OP_BULK = 2'd3
  } op_e;
endpackage

// File: rtl/eep_pgm_timer.sv
module eep_pgm_timer #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MIN_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic long_enough_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] elapsed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (arm_i) start_q <= cnt_q;
    end
  end

  // modular difference stays correct across counter wrap
  assign elapsed       = cnt_q - start_q;
  assign long_enough_o = (elapsed >= CNT_W'(MIN_CYCLES));
endmodule

// File: rtl/eep_ctl_unit.sv
module eep_ctl_unit
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              arr_we_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [7:0]        arr_wdata_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              long_enough_i,
  output logic [7:0]        ctl_o,
  output logic              arm_o,
  output logic              commit_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] caddr_o,
  output logic [7:0]        cdata_o,
  output logic              err_ill_o,
  output logic              err_seq_o,
  output logic              err_time_o,
  output logic              err_wr_o
);
  localparam logic [ADDR_W-1:0] CFG_IDX = ADDR_W'(DEPTH - 1);

  logic [7:0]        ctl_q;
  logic              pend_q;
  logic [ADDR_W-1:0] laddr_q;
  logic [7:0]        ldata_q;

  logic [7:0]        newly_set;
  logic [7:0]        ctl_n;
  logic              illegal, wr_ok, rise, fall;
  logic              lat_req, lat_ok;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;

  always_comb begin
    newly_set = ~ctl_q & ctl_wdata_i;
    illegal   = ctl_we_i && newly_set[CB_LAT] && newly_set[CB_PGM];
    wr_ok     = ctl_we_i && !illegal;
    ctl_n     = ctl_wdata_i[CB_LAT] ? ctl_wdata_i : 8'h00;
    rise      = wr_ok && ctl_n[CB_PGM] && !ctl_q[CB_PGM];
    fall      = wr_ok && !ctl_n[CB_PGM] && ctl_q[CB_PGM];

    lat_req  = cfg_we_i || (arr_we_i && (arr_addr_i != CFG_IDX));
    lat_addr = cfg_we_i ? CFG_IDX : arr_addr_i;
    lat_data = cfg_we_i ? cfg_wdata_i : arr_wdata_i;
    lat_ok   = lat_req && ctl_q[CB_LAT] && !pend_q;

    // erase size follows the mode held during the voltage pulse
    if (!ctl_q[CB_ERASE])                          op_o = OP_PROG;
    else if (ctl_q[CB_BYTE] || laddr_q == CFG_IDX) op_o = OP_BYTE;
    else if (ctl_q[CB_ROW])                        op_o = OP_ROW;
    else                                           op_o = OP_BULK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= 8'h00;
      pend_q  <= 1'b0;
      laddr_q <= '0;
      ldata_q <= 8'h00;
    end else begin
      if (wr_ok) ctl_q <= ctl_n;
      if (fall) begin
        pend_q <= 1'b0;
      end else if (lat_ok) begin
        pend_q  <= 1'b1;
        laddr_q <= lat_addr;
        ldata_q <= lat_data;
      end
    end
  end

  assign ctl_o      = ctl_q;
  assign arm_o      = rise;
  assign commit_o   = fall && pend_q && long_enough_i;
  assign caddr_o    = laddr_q;
  assign cdata_o    = ldata_q;
  assign err_ill_o  = illegal;
  assign err_seq_o  = wr_ok && ctl_n[CB_PGM] && (!ctl_q[CB_LAT] || !pend_q);
  assign err_time_o = fall && !long_enough_i;
  assign err_wr_o   = lat_req && !lat_ok;
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ROW_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        cfg_byte_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int RW    = $clog2(ROW_BYTES);
  localparam logic [ADDR_W-1:0] CFG_IDX = ADDR_W'(DEPTH - 1);

  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [7:0] cell_q = 8'hFF;
    logic       hit;

    always_comb begin
      unique case (op_i)
        OP_PROG, OP_BYTE: hit = (addr_i == IDX);
        OP_ROW:           hit = (addr_i[ADDR_W-1:RW] == IDX[ADDR_W-1:RW]);
        default:          hit = 1'b1;
      endcase
    end

    // nonvolatile contents: no reset
    always_ff @(posedge clk_i) begin
      if (commit_i && hit)
        cell_q <= (op_i == OP_PROG) ? (cell_q & data_i) : 8'hFF;
    end

    assign cells[i] = cell_q;
  end

  assign rd_data_o  = (rd_addr_i == CFG_IDX) ? 8'hFF : cells[rd_addr_i];
  assign cfg_byte_o = cells[DEPTH-1];
endmodule

// File: rtl/eep_seq_ctrl.sv
module eep_seq_ctrl
  import eep_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          ROW_BYTES  = 16,
  parameter int unsigned MIN_CYCLES = 10000,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              arr_we_i,
  input  logic              arr_re_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [7:0]        arr_wdata_i,
  output logic [7:0]        arr_rdata_o,
  input  logic              err_clr_i,
  output logic [4:0]        err_o,
  output logic              arr_en_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        ctl;
  logic              arm, long_enough, commit;
  op_e               op;
  logic [ADDR_W-1:0] caddr;
  logic [7:0]        cdata, rd_data, cfg_byte;
  logic              e_ill, e_seq, e_time, e_wr;
  logic [ERR_W-1:0]  err_set, err_q;
  logic [7:0]        cfg_q;
  logic              cfg_ld_q;

  eep_pgm_timer #(
    .CNT_W     (CNT_W),
    .MIN_CYCLES(MIN_CYCLES)
  ) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm),
    .long_enough_o(long_enough)
  );

  eep_ctl_unit #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_we_i     (ctl_we_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .arr_we_i     (arr_we_i),
    .arr_addr_i   (arr_addr_i),
    .arr_wdata_i  (arr_wdata_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .long_enough_i(long_enough),
    .ctl_o        (ctl),
    .arm_o        (arm),
    .commit_o     (commit),
    .op_o         (op),
    .caddr_o      (caddr),
    .cdata_o      (cdata),
    .err_ill_o    (e_ill),
    .err_seq_o    (e_seq),
    .err_time_o   (e_time),
    .err_wr_o     (e_wr)
  );

  eep_array #(
    .ADDR_W   (ADDR_W),
    .ROW_BYTES(ROW_BYTES)
  ) i_array (
    .clk_i     (clk_i),
    .commit_i  (commit),
    .op_i      (op),
    .addr_i    (caddr),
    .data_i    (cdata),
    .rd_addr_i (arr_addr_i),
    .rd_data_o (rd_data),
    .cfg_byte_o(cfg_byte)
  );

  always_comb begin
    err_set         = '0;
    err_set[E_ILL]  = e_ill;
    err_set[E_SEQ]  = e_seq;
    err_set[E_TIME] = e_time;
    err_set[E_WR]   = e_wr;
    err_set[E_RD]   = arr_re_i && ctl[CB_LAT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= '0;
      cfg_q    <= 8'h00;
      cfg_ld_q <= 1'b0;
    end else begin
      err_q <= (err_clr_i ? '0 : err_q) | err_set;
      // stored byte is sampled once per reset
      if (!cfg_ld_q) begin
        cfg_q    <= cfg_byte;
        cfg_ld_q <= 1'b1;
      end
    end
  end

  assign ctl_rdata_o = ctl;
  assign cfg_rdata_o = cfg_q;
  assign arr_en_o    = cfg_ld_q && cfg_q[CFG_EN_BIT];
  assign arr_rdata_o = arr_en_o ? rd_data : 8'h00;
  assign err_o       = err_q;
endmodule

// File: rtl/eep_seq_ctrl_chk.sv
module eep_seq_ctrl_chk
  import eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       arr_re_i,
  input logic       err_clr_i,
  input logic [4:0] err_o,
  input logic [7:0] cfg_rdata_o,
  input logic       cfg_ld_q
);
  p_illegal_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[CB_LAT] && ctl_wdata_i[CB_PGM]
     && !ctl_rdata_o[CB_LAT] && !ctl_rdata_o[CB_PGM])
    |=> ($stable(ctl_rdata_o) && err_o[E_ILL]));

  p_zero_on_unlatch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_wdata_i[CB_LAT]) |=> (ctl_rdata_o == 8'h00));

  p_pgm_needs_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[CB_PGM] |-> ctl_rdata_o[CB_LAT]);

  p_read_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_re_i && ctl_rdata_o[CB_LAT]) |=> err_o[E_RD]);

  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ld_q |=> $stable(cfg_rdata_o));

  p_err_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));
endmodule

bind eep_seq_ctrl eep_seq_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_we_i   (ctl_we_i),
  .ctl_wdata_i(ctl_wdata_i),
  .ctl_rdata_o(ctl_rdata_o),
  .arr_re_i   (arr_re_i),
  .err_clr_i  (err_clr_i),
  .err_o      (err_o),
  .cfg_rdata_o(cfg_rdata_o),
  .cfg_ld_q   (cfg_ld_q)
);

// File: tb/test_eep_seq_ctrl.sv
`timescale 1ns/1ps
module test_eep_seq_ctrl;
  localparam int AW = 6;
  localparam int DEPTH = 64;
  localparam int MINC = 32;
  localparam logic [7:0] PGM = 8'h01, LAT = 8'h02, ERS = 8'h04, ROW = 8'h08, BYT = 8'h10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctl_we = 1'b0, cfg_we = 1'b0, arr_we = 1'b0, arr_re = 1'b0, err_clr = 1'b0;
  logic [7:0] ctl_wd = '0, cfg_wd = '0, arr_wd = '0;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0] ctl_rd, cfg_rd, arr_rd;
  logic [4:0] err;
  logic arr_en;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] d;

  always #4 clk = ~clk;

  eep_seq_ctrl #(.ADDR_W(AW), .ROW_BYTES(16), .MIN_CYCLES(MINC), .CNT_W(32)) i_eep_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .ctl_rdata_o(ctl_rd),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .arr_we_i(arr_we), .arr_re_i(arr_re), .arr_addr_i(arr_addr),
    .arr_wdata_i(arr_wd), .arr_rdata_o(arr_rd),
    .err_clr_i(err_clr), .err_o(err), .arr_en_o(arr_en));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wd = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic arr_wr(input int a, input logic [7:0] v);
    arr_we = 1'b1; arr_addr = AW'(a); arr_wd = v; @(negedge clk); arr_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wd = v; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    arr_addr = AW'(a); arr_re = 1'b1; #1 v = arr_rd; @(negedge clk); arr_re = 1'b0;
  endtask

  task automatic clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; idle(2); rst_ni = 1'b1; idle(1);
  endtask

  function automatic void model_apply(input logic [7:0] mode, input int a, input logic [7:0] v);
    if (!mode[2]) mdl[a] = mdl[a] & v;
    else if (mode[4] || a == DEPTH-1) mdl[a] = 8'hFF;
    else if (mode[3]) begin
      for (int j = 0; j < DEPTH; j++) if ((j >> 4) == (a >> 4)) mdl[j] = 8'hFF;
    end else begin
      for (int j = 0; j < DEPTH; j++) mdl[j] = 8'hFF;
    end
  endfunction

  // full sequence: latch, pair, voltage on, hold, voltage off
  task automatic do_op(input logic [7:0] mode, input int a, input logic [7:0] v,
                       input int hold, input bit use_cfg);
    ctl_wr(LAT | mode);
    if (use_cfg) cfg_wr(v); else arr_wr(a, v);
    ctl_wr(LAT | PGM | mode);
    idle(hold - 1);
    ctl_wr(8'h00);
    if (hold >= MINC) model_apply(mode, use_cfg ? DEPTH-1 : a, v);
  endtask

  task automatic check_all(input string req);
    bit ok = 1'b1;
    for (int j = 0; j < DEPTH-1; j++) begin
      rd(j, d);
      if (ok && d !== mdl[j]) begin
        ok = 1'b0;
        $display("FAIL %s: addr %0d actual %h expected %h", req, j, d, mdl[j]);
      end
    end
    n_chk++;
    if (!ok) n_fail++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int j = 0; j < DEPTH; j++) mdl[j] = 8'hFF;
    idle(1);
    do_reset();
    // R11 reset state
    check("R11 ctl", ctl_rd, 8'h00);
    check("R11 err", {3'b0, err}, 8'h00);
    check("R11 cfg", cfg_rd, 8'hFF);
    check("R12 en", {7'b0, arr_en}, 8'h01);
    rd(5, d); check("R11 erased read", d, 8'hFF);

    // R1 illegal simultaneous set
    ctl_wr(LAT | PGM);
    check("R1 ctl kept", ctl_rd, 8'h00);
    check("R1 err", {3'b0, err}, 8'h01);
    clr();

    // R2 lat clear zeroes control
    ctl_wr(LAT | ERS);
    check("R2 set", ctl_rd, 8'h06);
    ctl_wr(ERS | ROW);
    check("R2 zero", ctl_rd, 8'h00);

    // R3 voltage without pair, then R5 short pulse
    ctl_wr(LAT);
    ctl_wr(LAT | PGM);
    ctl_wr(8'h00);
    check("R3 R5 err", {3'b0, err}, 8'h06);
    clr();

    // R4 second pair rejected; R6 programming
    ctl_wr(LAT);
    arr_wr(3, 8'h5A);
    arr_wr(4, 8'h00);
    ctl_wr(LAT | PGM);
    idle(MINC - 1);
    ctl_wr(8'h00);
    mdl[3] = 8'h5A;
    check("R4 err", {3'b0, err}, 8'h08);
    clr();
    rd(3, d); check("R6 prog", d, 8'h5A);
    rd(4, d); check("R4 second not latched", d, 8'hFF);
    do_op(8'h00, 3, 8'hF0, MINC, 1'b0);
    rd(3, d); check("R6 and", d, 8'h50);
    arr_wr(9, 8'h00);
    check("R4 no lat err", {3'b0, err}, 8'h08);
    clr();

    // R5 boundary
    do_op(8'h00, 7, 8'h00, MINC - 1, 1'b0);
    check("R5 short err", {3'b0, err}, 8'h04);
    clr();
    rd(7, d); check("R5 short no commit", d, 8'hFF);
    do_op(8'h00, 7, 8'h00, MINC, 1'b0);
    check("R5 exact err", {3'b0, err}, 8'h00);
    rd(7, d); check("R5 exact commit", d, 8'h00);

    // R7 byte erase
    do_op(ERS | BYT, 3, 8'h00, MINC, 1'b0);
    rd(3, d); check("R7 byte", d, 8'hFF);
    rd(7, d); check("R7 neighbour", d, 8'h00);

    // R10 read while latched
    ctl_wr(LAT);
    rd(7, d); check("R10 data", d, 8'h00);
    check("R10 err", {3'b0, err}, 8'h10);
    ctl_wr(8'h00);
    clr();

    // R8 row erase mid-row
    do_op(8'h00, 15, 8'h00, MINC, 1'b0);
    do_op(8'h00, 16, 8'h00, MINC, 1'b0);
    do_op(8'h00, 31, 8'h00, MINC, 1'b0);
    do_op(8'h00, 48, 8'h00, MINC, 1'b0);
    do_op(ERS | ROW, 20, 8'h00, MINC, 1'b0);
    check_all("R8 row");

    // R11/R12 config takes effect after reset only
    do_op(8'h00, 0, 8'hFE, MINC, 1'b1);
    check("R11 live unchanged", cfg_rd, 8'hFF);
    rd(63, d); check("R10 cfg hidden", d, 8'hFF);
    do_reset();
    check("R11 cfg loaded", cfg_rd, 8'hFE);
    check("R12 unmapped", {7'b0, arr_en}, 8'h00);
    rd(16, d); check("R12 read zero", d, 8'h00);

    // R7 erase aimed at config is byte-only
    do_op(8'h00, 60, 8'h00, MINC, 1'b0);
    do_op(ERS | ROW, 0, 8'h00, MINC, 1'b1);
    do_reset();
    check("R7 cfg erased", cfg_rd, 8'hFF);
    rd(60, d); check("R7 row kept", d, 8'h00);

    // R8 last row reaches config byte
    do_op(8'h00, 0, 8'hFE, MINC, 1'b1);
    do_op(ERS | ROW, 50, 8'h00, MINC, 1'b0);
    do_reset();
    check("R8 last row cfg", cfg_rd, 8'hFF);
    check_all("R8 last row");

    // R9 bulk
    do_op(8'h00, 0, 8'hFE, MINC, 1'b1);
    do_op(8'h00, 0, 8'h00, MINC, 1'b0);
    do_op(ERS, 5, 8'h00, MINC, 1'b0);
    check_all("R9 bulk");
    do_reset();
    check("R9 cfg", cfg_rd, 8'hFF);

    // R13 sticky and clear race
    arr_wr(2, 8'h00);
    idle(5);
    check("R13 sticky", {3'b0, err}, 8'h08);
    err_clr = 1'b1; arr_we = 1'b1; arr_addr = 6'd2; @(negedge clk);
    err_clr = 1'b0; arr_we = 1'b0;
    check("R13 set wins", {3'b0, err}, 8'h08);
    clr();
    check("R13 cleared", {3'b0, err}, 8'h00);

    // random sequences around the hold limit
    for (int k = 0; k < 24; k++) begin
      logic [7:0] mode;
      int a, hold;
      logic [7:0] v;
      case ($urandom % 4)
        0: mode = 8'h00;
        1: mode = ERS | BYT;
        2: mode = ERS | ROW;
        default: mode = ((k % 3) == 0) ? ERS : 8'h00;
      endcase
      a = int'($urandom % (DEPTH - 1));
      v = 8'($urandom);
      hold = MINC - 2 + int'($urandom % 5);
      do_op(mode, a, v, hold, 1'b0);
      check("R5 R6 R7 R8 R9 rand err", {3'b0, err}, (hold < MINC) ? 8'h04 : 8'h00);
      clr();
      check_all("R6 R7 R8 R9 rand");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule